// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block sits between a physical-layer link-good indication and the logic that acts on link state. It reports the link as up only after the raw indication has stayed good, with no break, for a hold time chosen by a 3-bit code. The eight codes run from no hold at all up to two seconds. Time is measured in ticks of a free-running tick input. The parameter `US_PER_TICK` gives the tick spacing in microseconds, and each hold time is rounded up to a whole number of ticks.

A loss of the raw indication is never filtered. The qualified flag drops on the next clock edge, and any qualification in progress starts over. Each change of the qualified state raises a one-cycle event pulse at the same time as the new flag value.

The hold code is plain control, and no data stream passes through the block, so no valid/ready interface is used. The code is read on every edge when no qualification is in progress. A qualification uses the code read on the last such edge.

Top module: `link_stability_qual`

## Requirements
- R1: While reset is asserted, `link_up` and `link_evt` are 0. The captured hold code after reset is 2 (1 ms), so a raw-good signal already present when reset is released is qualified against 1 ms, whatever `period_sel` shows.
- R2: The hold time for each `period_sel` value is: 7 = 2 s, 3 = 64 ms, 0 = none, 5 = 512 ms, 1 = 500 us, 6 = 1 s, 2 = 1 ms, 4 = 256 ms. In ticks it is ceil(time_us / US_PER_TICK).
- R3: Call the hold time T ticks. Counting starts at the first edge that samples `raw_link_ok` = 1 while `link_up` = 0. `link_up` rises at the edge that samples the T-th tick of the unbroken good run. When T is 0, it rises at the first such edge.
- R4: Any edge that samples `raw_link_ok` = 0 clears the tick count. A later good run counts the full hold time from zero. Ticks sampled while the raw signal is low have no effect.
- R5: An edge that samples `raw_link_ok` = 0 while `link_up` = 1 clears `link_up` at that edge, with no filtering.
- R6: `link_evt` is 1 for exactly the one cycle in which `link_up` shows a new value, on both rise and fall, and is 0 at all other times.
- R7: `period_sel` is captured on every edge where no qualification is in progress (raw low, or link already up). A change of `period_sel` during a qualification does not alter that qualification's hold time.
- R8: Ticks that arrive sparsely (not every cycle) are counted one by one, so the hold time follows the tick count and not the cycle count.
- R9: While `link_up` = 1 and `raw_link_ok` stays 1, `link_up` stays 1 whatever ticks or code changes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle time tick, one every US_PER_TICK microseconds |
| raw_link_ok | input | 1 | Unfiltered link-good from the physical layer |
| period_sel | input | 3 | Hold-time code (see R2) |
| link_up | output | 1 | Qualified link state |
| link_evt | output | 1 | One-cycle pulse on every change of link_up |

## Verification
The bench runs with `US_PER_TICK` = 500, so the hold times become 0, 1, 2, 128, 512, 1024, 2000 and 4000 ticks. Every code is tried with an unbroken good run and ticks on every cycle. This separates codes 0 and 1, which both qualify on the first edge, from the longer codes, and it confirms that the 2 s count fits the counter. A good run broken by one low cycle shows whether the count restarts or carries on. Sparse ticks show whether the block counts ticks or cycles. A code change in the middle of a qualification, and a good signal held through reset, show when the code is captured. Raw toggling on every cycle with code 0 shows that an event pulse fires for each change of link state.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  localparam int unsigned CODE_W       = 3;
  localparam int unsigned NUM_CODES    = 1 << CODE_W;
  localparam int unsigned DEFAULT_CODE = 2;
  localparam int unsigned MAX_HOLD_US  = 2000000;

  // Hold time in microseconds for each code.
  function automatic int unsigned hold_us(input int unsigned code);
    case (code)
      0:       return 0;
      1:       return 500;
      2:       return 1000;
      3:       return 64000;
      4:       return 256000;
      5:       return 512000;
      6:       return 1000000;
      default: return 2000000;
    endcase
  endfunction

  // Hold time rounded up to whole ticks.
  function automatic int unsigned hold_ticks(input int unsigned code,
                                             input int unsigned us_per_tick);
    return (hold_us(code) + us_per_tick - 1) / us_per_tick;
  endfunction

endpackage

// File: rtl/lsq_period_latch.sv
module lsq_period_latch #(
  parameter int unsigned US_PER_TICK = 1,
  parameter int unsigned CNT_W       = 21
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      capture,
  input  logic [lsq_pkg::CODE_W-1:0] code,
  output logic [CNT_W-1:0]          target
);
  import lsq_pkg::*;

  logic [CNT_W-1:0] tbl [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tbl
    assign tbl[g] = CNT_W'(hold_ticks(g, US_PER_TICK));
  end

  localparam logic [CNT_W-1:0] RST_TARGET = CNT_W'(hold_ticks(DEFAULT_CODE, US_PER_TICK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       target <= RST_TARGET;
    else if (capture) target <= tbl[code];
  end

endmodule

// File: rtl/lsq_hold_counter.sv
module lsq_hold_counter #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             reached
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_sum;

  assign cnt_sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, tick};
  assign reached = run && (cnt_sum >= {1'b0, target});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (run && !reached)   cnt_q <= cnt_sum[CNT_W-1:0];
    else                        cnt_q <= '0;
  end

endmodule

// File: rtl/lsq_state_evt.sv
module lsq_state_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_ok,
  input  logic reached,
  output logic up_q,
  output logic evt_q
);

  logic up_d;

  always_comb begin
    up_d = up_q;
    if (!raw_ok)      up_d = 1'b0;
    else if (reached) up_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      up_q  <= up_d;
      evt_q <= up_d ^ up_q;
    end
  end

endmodule

// File: rtl/link_stability_qual.sv
module link_stability_qual #(
  parameter int unsigned US_PER_TICK = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       raw_link_ok,
  input  logic [2:0] period_sel,
  output logic       link_up,
  output logic       link_evt
);
  import lsq_pkg::*;

  localparam int unsigned MAX_TICKS = (MAX_HOLD_US + US_PER_TICK - 1) / US_PER_TICK;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             qualifying;
  logic             reached;
  logic [CNT_W-1:0] target;

  assign qualifying = raw_link_ok && !link_up;

  lsq_period_latch #(.US_PER_TICK(US_PER_TICK), .CNT_W(CNT_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (!qualifying),
    .code    (period_sel),
    .target  (target)
  );

  lsq_hold_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (qualifying),
    .tick    (us_tick),
    .target  (target),
    .reached (reached)
  );

  lsq_state_evt u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_ok  (raw_link_ok),
    .reached (reached),
    .up_q    (link_up),
    .evt_q   (link_evt)
  );

endmodule

// File: rtl/link_stability_qual_chk.sv
module link_stability_qual_chk (
  input logic clk,
  input logic rst_n,
  input logic raw_link_ok,
  input logic link_up,
  input logic link_evt
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (!link_up && !link_evt));

  // R5
  drop_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_link_ok |=> !link_up);

  // R3
  rise_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(raw_link_ok));

  // R6
  evt_only_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |-> (link_up != $past(link_up)));

  // R6
  change_has_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up != $past(link_up)) |-> link_evt);

  // R9
  stay_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && raw_link_ok) |=> link_up);

endmodule

bind link_stability_qual link_stability_qual_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .raw_link_ok (raw_link_ok),
  .link_up     (link_up),
  .link_evt    (link_evt)
);

// File: tb/link_stability_qual_tb.sv
`timescale 1ns/1ps
module link_stability_qual_tb;

  localparam int UPT = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic raw_link_ok = 1'b0;
  logic [2:0] period_sel = 3'd0;
  logic link_up, link_evt;

  int errors = 0;
  int checks = 0;
  int tick_div = 1;
  int tick_phase = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  link_stability_qual #(.US_PER_TICK(UPT)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .raw_link_ok(raw_link_ok),
    .period_sel(period_sel), .link_up(link_up), .link_evt(link_evt)
  );

  function automatic int ref_ticks(input int code);
    int us;
    case (code)
      0: us = 0;        1: us = 500;      2: us = 1000;     3: us = 64000;
      4: us = 256000;   5: us = 512000;   6: us = 1000000;  default: us = 2000000;
    endcase
    return (us + UPT - 1) / UPT;
  endfunction

  // Behavioural reference, updated on each rising edge.
  int  m_cnt = 0;
  int  m_tgt = 2;
  bit  m_up = 0;
  bit  m_evt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_up = 0; m_evt = 0; m_cnt = 0; m_tgt = ref_ticks(2);
    end else begin
      bit attempt, nup;
      attempt = raw_link_ok && !m_up;
      nup = m_up;
      if (!raw_link_ok) nup = 0;
      else if (attempt && (m_cnt + int'(us_tick) >= m_tgt)) nup = 1;
      m_evt = (nup != m_up);
      if (attempt && !nup) m_cnt = m_cnt + int'(us_tick);
      else m_cnt = 0;
      if (!attempt) m_tgt = ref_ticks(int'(period_sel));
      m_up = nup;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison and tick generation.
  always @(negedge clk) begin
    if (!done) begin
      check(link_up == m_up, {cur_req, " link_up"}, int'(link_up), int'(m_up));
      check(link_evt == m_evt, {cur_req, " link_evt"}, int'(link_evt), int'(m_evt));
    end
    if (tick_div <= 1) us_tick <= 1'b1;
    else begin
      us_tick <= (tick_phase == 0);
      tick_phase = (tick_phase + 1) % tick_div;
    end
  end

  task automatic go_down();
    raw_link_ok = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input int code, input string req);
    int n, exp;
    period_sel = 3'(code);
    go_down();
    raw_link_ok = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!link_up && n < 10000);
    exp = (ref_ticks(code) < 1) ? 1 : ref_ticks(code);
    check(n == exp, req, n, exp);
  endtask

  initial begin
    // R1: reset state, default code applied with raw good at release
    raw_link_ok = 1; period_sel = 3'd7;
    repeat (3) @(negedge clk);
    check(!link_up && !link_evt, "R1 reset", int'(link_up), 0);
    rst_n = 1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!link_up && n < 100);
      check(n == 2, "R1 default code", n, 2);
    end

    // R5/R6: immediate drop with event
    cur_req = "R5";
    raw_link_ok = 0;
    @(negedge clk);
    check(!link_up, "R5 drop", int'(link_up), 0);
    check(link_evt, "R6 fall evt", int'(link_evt), 1);
    @(negedge clk);
    check(!link_evt, "R6 single pulse", int'(link_evt), 0);

    // R2/R3: every code
    cur_req = "R2";
    for (int c = 0; c < 8; c++) measure(c, (c == 0) ? "R3 code0" : "R2 code");

    // R4: interrupted run restarts
    cur_req = "R4";
    period_sel = 3'd3;
    go_down();
    raw_link_ok = 1;
    repeat (100) @(negedge clk);
    raw_link_ok = 0;
    @(negedge clk);
    raw_link_ok = 1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!link_up && n < 1000);
      check(n == 128, "R4 restart", n, 128);
    end

    // R7: code change mid-attempt ignored
    cur_req = "R7";
    period_sel = 3'd4;
    go_down();
    raw_link_ok = 1;
    repeat (10) @(negedge clk);
    period_sel = 3'd0;
    begin
      int n = 10;
      do begin @(negedge clk); n++; end while (!link_up && n < 2000);
      check(n == 512, "R7 latched code", n, 512);
    end

    // R9: stays up through code changes and ticks
    cur_req = "R9";
    for (int i = 0; i < 40; i++) begin
      period_sel = 3'(i % 8);
      @(negedge clk);
      check(link_up && !link_evt, "R9 hold", int'(link_up), 1);
    end

    // R8: sparse ticks
    cur_req = "R8";
    period_sel = 3'd3;
    go_down();
    tick_div = 3;
    raw_link_ok = 1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!link_up && n < 1000);
      check(n >= 382 && n <= 384, "R8 sparse ticks", n, 383);
    end
    tick_div = 1;

    // R6: toggling raw with code 0
    cur_req = "R6";
    period_sel = 3'd0;
    go_down();
    begin
      int c = 0;
      raw_link_ok = 1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (link_evt) c++;
        if (i < 5) raw_link_ok = ~raw_link_ok;
      end
      check(c == 6, "R6 toggle events", c, 6);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule